// File: doc/BRIEF.md
# Three-wire codec control writer

This block writes control bytes to an audio codec over a three-wire bus of MODE, CLOCK and DATA lines. A settings sequencer hands it a request as a byte stream: the first beat chooses a register selector, and one or more data bytes follow. The block first sends an address byte with MODE low, then each data byte with MODE high. Every byte goes out least significant bit first. DATA changes only on the falling edge of CLOCK, and CLOCK and MODE return high after every byte. All phase lengths come from a parameter that gives the system clock period.

The request stream is valid/ready. A beat transfers on a rising clock edge where both `in_valid` and `in_ready` are high. `in_ready` is high only while the block is idle or waiting between bytes of an open request, so the sender must hold the beat steady until it is taken. A beat with `in_last` set closes the request. Between bytes the sender may stall for as long as it needs. The bus then holds both CLOCK and MODE high, and `busy` stays high. `busy` and `done` are plain status pins.

With the default 20 ns system clock the setup interval is 10 cycles (200 ns). Each CLOCK half period is 13 cycles, so a full bit takes 520 ns.

Top module: `cbus_writer`

## Requirements
- R1: During reset and after it, MODE, CLOCK and DATA are high, `busy` and `done` are low and `in_ready` is high.
- R2: The first beat of a request is sent as the address byte with MODE low for the whole byte. The byte sent is the device identifier 000101 in bits 7:2 with the beat's bits 1:0 in bits 1:0, which gives 0x14 plus the selector. Selector 0 is the data register and selector 2 is the status register.
- R3: Bits are sent least significant first. DATA takes the bit value at the CLOCK falling edge and does not change while CLOCK is high.
- R4: Within a byte, CLOCK is low for 13 cycles and high for 13 cycles for each bit.
- R5: For an address byte, the first CLOCK falling edge comes 10 cycles after MODE falls. MODE falls on the accepting edge.
- R6: One address byte may be followed by several data bytes and no new address. Each data byte is sent with MODE high for the whole byte.
- R7: After each byte, CLOCK and MODE are high. They stay high for as long as the block waits for the next beat.
- R8: If `in_halt` is set on a data beat, CLOCK stays high for 10 extra cycles before that byte's setup interval. Without a stall, the gap from the last rising CLOCK edge of one byte to the first falling edge of the next is 24 cycles, or 34 cycles with a halt. `in_halt` on an address beat has no effect.
- R9: `in_ready` is low while a byte is being sent. When the byte flagged `in_last` is complete, `done` pulses for one cycle, 13 cycles after its last CLOCK rise, and `busy` falls in the same cycle.
- R10: Bits 7:2 of the address beat are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request beat valid |
| in_ready | output | 1 | Block can take a beat |
| in_byte | input | 8 | Beat payload: selector in bits 1:0 on the first beat, data byte after that |
| in_last | input | 1 | Beat closes the request |
| in_halt | input | 1 | Hold CLOCK high before this data byte |
| ctl_mode | output | 1 | Bus MODE line |
| ctl_clk | output | 1 | Bus CLOCK line |
| ctl_data | output | 1 | Bus DATA line |
| busy | output | 1 | A request is open |
| done | output | 1 | One-cycle pulse when a request completes |

## Verification
The bus lines, `in_ready` and `busy` are registered and all change on the same edge as the internal phase counter. Each result is therefore due a fixed number of cycles after its trigger:
- MODE falls on the accepting edge.
- The first CLOCK fall comes 10 cycles after that.
- Each CLOCK half period lasts 13 cycles.
- `done` comes 13 cycles after the final CLOCK rise.

The bench keeps a cycle counter and a bus monitor that sample on the falling system clock edge. They record the edge times and compare the differences with these exact counts, not with a window. Handshake checks are taken one half cycle after the accepting edge.

// File: rtl/cbus_pkg.sv
package cbus_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_NEXT,
    ST_HALT,
    ST_SETUP,
    ST_LO,
    ST_HI
  } cbus_st_e;
endpackage

// File: rtl/cbus_tick.sv
module cbus_tick #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/cbus_shift.sv
module cbus_shift #(
  parameter int BITS = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [BITS-1:0] load_val,
  input  logic            shift,
  output logic            bit0,
  output logic            bit1,
  output logic            last
);
  localparam int CW = $clog2(BITS);

  logic [BITS-1:0] sr;
  logic [CW-1:0]   idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr  <= '0;
      idx <= '0;
    end else if (load) begin
      sr  <= load_val;
      idx <= '0;
    end else if (shift) begin
      sr  <= {1'b0, sr[BITS-1:1]};
      idx <= idx + 1'b1;
    end
  end

  assign bit0 = sr[0];
  assign bit1 = sr[1];
  assign last = (idx == CW'(BITS - 1));

  // R6: the controller never shifts beyond the final bit of a byte
  a_r6_no_shift_past_last: assert property (@(posedge clk) disable iff (!rst_n)
    shift |-> !last);
endmodule

// File: rtl/cbus_writer.sv
module cbus_writer #(
  parameter int         SYS_CLK_NS = 20,
  parameter int         SETUP_NS   = 200,
  parameter int         HALF_NS    = 260,
  parameter logic [5:0] DEV_ID     = 6'b000101
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [7:0] in_byte,
  input  logic       in_last,
  input  logic       in_halt,
  output logic       ctl_mode,
  output logic       ctl_clk,
  output logic       ctl_data,
  output logic       busy,
  output logic       done
);
  import cbus_pkg::*;

  localparam int S_RAW = (SETUP_NS + SYS_CLK_NS - 1) / SYS_CLK_NS;
  localparam int H_RAW = (HALF_NS + SYS_CLK_NS - 1) / SYS_CLK_NS;
  localparam int S_CYC = (S_RAW < 1) ? 1 : S_RAW;
  localparam int H_CYC = (H_RAW < 1) ? 1 : H_RAW;
  localparam int MAXC  = (S_CYC > H_CYC) ? S_CYC : H_CYC;
  localparam int TW    = $clog2(MAXC) + 1;

  cbus_st_e     state, state_d;
  logic         mode_q, clk_q, data_q, last_q, done_q;
  logic         mode_d, clk_d, data_d, last_d, done_d;
  logic         tmr_load, tmr_zero;
  logic [TW-1:0] tmr_val;
  logic         sh_load, sh_shift, sh_b0, sh_b1, sh_last;
  logic [7:0]   sh_val;

  cbus_tick #(.W(TW)) u_tick (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .zero(tmr_zero)
  );

  cbus_shift #(.BITS(8)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(sh_load), .load_val(sh_val), .shift(sh_shift),
    .bit0(sh_b0), .bit1(sh_b1), .last(sh_last)
  );

  always_comb begin
    state_d  = state;
    mode_d   = mode_q;
    clk_d    = clk_q;
    data_d   = data_q;
    last_d   = last_q;
    done_d   = 1'b0;
    tmr_load = 1'b0;
    tmr_val  = TW'(S_CYC - 1);
    sh_load  = 1'b0;
    sh_val   = {DEV_ID, in_byte[1:0]};
    sh_shift = 1'b0;
    unique case (state)
      ST_IDLE: if (in_valid) begin
        sh_load  = 1'b1;
        last_d   = in_last;
        mode_d   = 1'b0;
        tmr_load = 1'b1;
        state_d  = ST_SETUP;
      end
      ST_NEXT: if (in_valid) begin
        sh_val   = in_byte;
        sh_load  = 1'b1;
        last_d   = in_last;
        tmr_load = 1'b1;
        state_d  = in_halt ? ST_HALT : ST_SETUP;
      end
      ST_HALT: if (tmr_zero) begin
        tmr_load = 1'b1;
        state_d  = ST_SETUP;
      end
      ST_SETUP: if (tmr_zero) begin
        tmr_load = 1'b1;
        tmr_val  = TW'(H_CYC - 1);
        clk_d    = 1'b0;
        data_d   = sh_b0;
        state_d  = ST_LO;
      end
      ST_LO: if (tmr_zero) begin
        tmr_load = 1'b1;
        tmr_val  = TW'(H_CYC - 1);
        clk_d    = 1'b1;
        state_d  = ST_HI;
      end
      ST_HI: if (tmr_zero) begin
        if (sh_last) begin
          mode_d  = 1'b1;
          done_d  = last_q;
          state_d = last_q ? ST_IDLE : ST_NEXT;
        end else begin
          sh_shift = 1'b1;
          tmr_load = 1'b1;
          tmr_val  = TW'(H_CYC - 1);
          clk_d    = 1'b0;
          data_d   = sh_b1;
          state_d  = ST_LO;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      mode_q <= 1'b1;
      clk_q  <= 1'b1;
      data_q <= 1'b1;
      last_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      state  <= state_d;
      mode_q <= mode_d;
      clk_q  <= clk_d;
      data_q <= data_d;
      last_q <= last_d;
      done_q <= done_d;
    end
  end

  assign in_ready = (state == ST_IDLE) || (state == ST_NEXT);
  assign busy     = (state != ST_IDLE);
  assign ctl_mode = mode_q;
  assign ctl_clk  = clk_q;
  assign ctl_data = data_q;
  assign done     = done_q;

  // R1: an idle block leaves the bus lines high
  a_r1_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (ctl_mode && ctl_clk));
  // R3: DATA is stable while CLOCK stays high
  a_r3_data_stable_clk_high: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_clk && $past(ctl_clk)) |-> $stable(ctl_data));
  // R7: MODE only moves while CLOCK is high
  a_r7_mode_edge_clk_high: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ctl_mode) |-> (ctl_clk && $past(ctl_clk)));
  // R7: while a beat can be taken the bus is parked high
  a_r7_ready_lines_high: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (ctl_clk && ctl_mode));
  // R9: done lasts a single cycle
  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: tb/sim_cbus_writer.sv
`timescale 1ns/1ps
module sim_cbus_writer;
  localparam int S = 10;
  localparam int H = 13;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [7:0] in_byte = 8'h00;
  logic in_last = 1'b0;
  logic in_halt = 1'b0;
  logic in_ready, ctl_mode, ctl_clk, ctl_data, busy, done;

  always #10 clk = ~clk;

  cbus_writer u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_byte(in_byte), .in_last(in_last), .in_halt(in_halt),
    .ctl_mode(ctl_mode), .ctl_clk(ctl_clk), .ctl_data(ctl_data),
    .busy(busy), .done(done)
  );

  // {ahalt, hmask[2:0], n[1:0], 2'b0} addr_beat d0 d1 d2
  localparam logic [39:0] VEC [6] = '{
    40'h04_00_3F_00_00,
    40'h04_FE_C1_00_00,
    40'h28_00_C2_4D_00,
    40'h88_02_80_01_00,
    40'h1C_53_A5_5A_FF,
    40'h04_01_00_00_00
  };

  int total = 0;
  int bad = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // bus monitor
  int ncap = 0, ndone = 0, bitn = 0;
  int t_rise = 0, t_fall = 0, t_mfall = 0, done_gap = 0;
  logic prev_clk = 1'b1, prev_mode = 1'b1;
  logic [7:0] shreg = 8'h00;
  logic [7:0] cap_byte [64];
  logic cap_mode [64];
  logic cap_mix [64];
  logic cap_wbad [64];
  int cap_gap [64];
  int cap_setup [64];

  always @(negedge clk) begin
    if (!rst_n) begin
      bitn = 0;
    end else begin
      if (prev_mode && !ctl_mode) t_mfall = cyc;
      if (prev_clk && !ctl_clk) begin
        if (bitn == 0) begin
          cap_gap[ncap]   = cyc - t_rise;
          cap_setup[ncap] = cyc - t_mfall;
          cap_mix[ncap]   = 1'b0;
          cap_wbad[ncap]  = 1'b0;
        end else if (cyc - t_rise != H) cap_wbad[ncap] = 1'b1;
        t_fall = cyc;
      end
      if (!prev_clk && ctl_clk) begin
        if (cyc - t_fall != H) cap_wbad[ncap] = 1'b1;
        shreg = {ctl_data, shreg[7:1]};
        if (bitn == 0) cap_mode[ncap] = ctl_mode;
        else if (ctl_mode != cap_mode[ncap]) cap_mix[ncap] = 1'b1;
        bitn = bitn + 1;
        t_rise = cyc;
        if (bitn == 8) begin
          cap_byte[ncap] = shreg;
          ncap = (ncap + 1) % 64;
          bitn = 0;
        end
      end
      if (done) begin
        ndone = ndone + 1;
        done_gap = cyc - t_rise;
      end
    end
    prev_clk  = ctl_clk;
    prev_mode = ctl_mode;
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send_req(input logic [39:0] v, input int stall);
    logic [7:0] beats [4];
    int n, base, nd0, tmo;
    logic stall_ok;
    n = int'(v[35:34]);
    beats[0] = v[31:24]; beats[1] = v[23:16]; beats[2] = v[15:8]; beats[3] = v[7:0];
    base = ncap; nd0 = ndone; stall_ok = 1'b1;
    for (int i = 0; i <= n; i++) begin
      @(negedge clk);
      if (stall > 0 && i == 2) begin
        in_valid = 1'b0;
        while (!in_ready) @(negedge clk);
        for (int k = 0; k < stall; k++) begin
          @(negedge clk);
          if (!(in_ready && busy && ctl_mode && ctl_clk)) stall_ok = 1'b0;
        end
        chk("R7 lines high while stalled", int'(stall_ok), 1);
      end
      in_byte  = beats[i];
      in_last  = (i == n);
      in_halt  = (i == 0) ? v[39] : v[35+i];
      in_valid = 1'b1;
      while (!in_ready) @(negedge clk);
      @(posedge clk);
      if (i == 0) begin
        @(negedge clk);
        chk("R9 ready low during byte", int'(in_ready), 0);
        chk("R9 busy during byte", int'(busy), 1);
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
    in_last  = 1'b0;
    in_halt  = 1'b0;
    tmo = 0;
    while (ndone == nd0 && tmo < 20000) begin
      @(negedge clk);
      tmo++;
    end
    chk("R9 one done pulse", ndone - nd0, 1);
    chk("R9 done 13 cycles after last rise", done_gap, H);
    chk("R9 busy low at done", int'(busy), 0);
    chk("R7 lines high after request", int'(ctl_mode && ctl_clk), 1);
    chk("R6 byte count", (ncap - base + 64) % 64, n + 1);
    chk("R2 R10 address byte", int'(cap_byte[base]), int'({6'b000101, beats[0][1:0]}));
    chk("R2 address mode low", int'(cap_mode[base]), 0);
    chk("R5 R8 address setup", cap_setup[base], S);
    for (int i = 0; i <= n; i++) begin
      chk("R4 half periods", int'(cap_wbad[(base+i)%64]), 0);
      chk("R6 mode constant in byte", int'(cap_mix[(base+i)%64]), 0);
    end
    for (int i = 1; i <= n; i++) begin
      chk("R3 data byte lsb first", int'(cap_byte[(base+i)%64]), int'(beats[i]));
      chk("R6 data mode high", int'(cap_mode[(base+i)%64]), 1);
      if (!(stall > 0 && i == 2))
        chk("R8 inter-byte gap", cap_gap[(base+i)%64], v[35+i] ? H + 1 + 2*S : H + 1 + S);
    end
  endtask

  task automatic run_all();
    // R1: reset state
    repeat (4) @(negedge clk);
    chk("R1 mode in reset", int'(ctl_mode), 1);
    chk("R1 clk in reset", int'(ctl_clk), 1);
    chk("R1 data in reset", int'(ctl_data), 1);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 busy after reset", int'(busy), 0);
    chk("R1 ready after reset", int'(in_ready), 1);
    chk("R1 done after reset", int'(done), 0);
    chk("R1 lines after reset", int'(ctl_mode && ctl_clk && ctl_data), 1);

    for (int t = 0; t < 6; t++) send_req(VEC[t], 0);

    // stall between data bytes
    send_req(40'h08_02_E7_18_00, 40);

    // reset in the middle of a byte
    @(negedge clk);
    in_byte = 8'h00; in_last = 1'b0; in_halt = 1'b0; in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    repeat (S + 3*H) @(negedge clk);
    chk("R1 mid-byte busy before reset", int'(busy), 1);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 lines high after mid reset", int'(ctl_mode && ctl_clk && ctl_data), 1);
    chk("R1 busy low after mid reset", int'(busy), 0);
    chk("R1 done low after mid reset", int'(done), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ready after mid reset", int'(in_ready), 1);
  endtask

  initial begin
    logic wd;
    wd = 1'b0;
    fork
      run_all();
      begin
        repeat (190000) @(posedge clk);
        wd = 1'b1;
      end
    join_any
    disable fork;
    if (wd) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule